// File: doc/BRIEF.md
# Memory Fill DMA Channel Controller

This block is a single DMA channel that writes a repeated 64-bit pattern over a region of memory. Software programs a small set of registers (a control word, a destination pointer, a block size in bytes and the pattern as two 32-bit halves), then drives one-cycle command pulses to start, pause, resume or abort the fill. The current channel state and a sticky error flag are visible at the ports at all times.

While the channel is active it offers one 64-bit write beat per cycle on a valid/ready port. Each beat carries the destination address and the pattern. The last beat before a burst boundary, or the last beat of the block, is flagged, so a downstream bus adapter can close its burst there. When the final beat is accepted the channel falls back to idle by itself and pulses a completion strobe.

Commands are filtered by the channel state. A command that the current state does not allow leaves the channel untouched and raises the sticky error flag. Software clears that flag by writing one to it.

Top module: `memfill_chan`

## Requirements
- R1: After reset the state reads idle, the error flag, the completion strobe and wr_valid are low, and the control word reads 32'h0000_4400 (both burst-limit fields equal 4, mode 0, protect 0).
- R2: The state output encodes idle as 2'b00, active as 2'b01 and paused as 2'b10. The code 2'b11 (undefined) never appears.
- R3: Start moves an idle or paused channel to active in the next cycle, reloading the fill from the destination pointer, provided the block size lies in [SIZE_MIN, SIZE_MAX]. A start while active, or with the size outside that range, sets the error flag and leaves the state unchanged.
- R4: Pause moves an active channel to paused. wr_valid drops and the next address is held. Pause in any other state sets the error flag.
- R5: Restart moves a paused channel to active and continues from the held address. Restart in any other state sets the error flag.
- R6: Stop returns an active channel to idle with no completion strobe. Stop while idle has no effect and raises no error. Stop while paused sets the error flag and keeps the channel paused.
- R7: When several commands arrive in one cycle, only the highest-priority one is evaluated (stop, then pause, then restart, then start). The others have no effect.
- R8: Register writes go to address 0 (control), 1 (destination pointer), 2 (block size), 3 (pattern low), 4 (pattern high) and 5 (error). A control write never changes bits [2:0] (operation mode), which only the mode-select input loads (3'b100 is memory init). The writable control bits are bit 4 (access protect), [11:8] (source burst limit) and [15:12] (destination burst limit); all other control bits read 0.
- R9: Beat k of a fill carries address (pointer with bits [2:0] cleared) + 8*k and data {high, low} as captured at the start. A fill has size/8 beats, with any remainder below 8 bytes dropped.
- R10: wr_last is high on a beat when it is the block's last beat, or when the following address is a multiple of 8 << L, where L is the destination burst-limit field.
- R11: A beat advances only when wr_valid and wr_ready are both high. While a beat is offered and not taken, its address and data stay stable.
- R12: When the last beat is accepted, the next cycle shows the state idle and done_o high for exactly one cycle.
- R13: The error flag is sticky. A write to address 5 with bit 0 set clears it; a write with bit 0 clear does not. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mode_we | input | 1 | Operation-mode load strobe |
| mode_val | input | 3 | Operation-mode value |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| ctrl_o | output | 32 | Control word readback |
| state_o | output | 2 | Channel state |
| err_o | output | 1 | Sticky error flag |
| done_o | output | 1 | One-cycle completion strobe |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_last | output | 1 | Last beat of burst or block |

## Verification
The bench builds the channel with SIZE_MIN = 16 and SIZE_MAX = 512, so a full block is at most 64 beats. That makes it practical to sweep pointer alignment, size (including both bounds and a non-multiple of 8), burst limits 0, 1, 2 and 4, and an irregular ready pattern, with every beat checked against arithmetic expectations. It also brings all twelve state/command pairs within reach. The small bounds make the out-of-range sizes on both sides cheap to try, and they leave room for mid-block pause, resume, abort and simultaneous-command cases.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_PAUSED = 2'b10
  } chan_st_e;

  localparam logic [2:0] MODE_MEMINIT = 3'b100;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_SIZE = 3'd2;
  localparam logic [2:0] RA_PLO  = 3'd3;
  localparam logic [2:0] RA_PHI  = 3'd4;
  localparam logic [2:0] RA_ERR  = 3'd5;

  localparam logic [31:0] CTRL_RST   = 32'h0000_4400;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_FF10;
endpackage

// File: rtl/memfill_regs.sv
module memfill_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              mode_we,
  input  logic [2:0]        mode_val,
  output logic [31:0]       ctrl_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [31:0]       size_q,
  output logic [63:0]       pat_q,
  output logic              err_clr
);
  import memfill_pkg::*;

  logic [31:0] ctrl_d;
  logic        ctrl_en, dst_en, size_en, plo_en, phi_en;

  assign dst_en  = reg_we && (reg_addr == RA_DST);
  assign size_en = reg_we && (reg_addr == RA_SIZE);
  assign plo_en  = reg_we && (reg_addr == RA_PLO);
  assign phi_en  = reg_we && (reg_addr == RA_PHI);
  assign err_clr = reg_we && (reg_addr == RA_ERR) && reg_wdata[0];
  assign ctrl_en = mode_we || (reg_we && (reg_addr == RA_CTRL));

  // Mode bits are only reachable through the dedicated select.
  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && (reg_addr == RA_CTRL))
      ctrl_d = (reg_wdata & CTRL_WMASK) | {29'd0, ctrl_q[2:0]};
    if (mode_we)
      ctrl_d[2:0] = mode_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dst_q  <= '0;
      size_q <= '0;
      pat_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q        <= ctrl_d;
      if (dst_en)  dst_q         <= reg_wdata[ADDR_W-1:0];
      if (size_en) size_q        <= reg_wdata;
      if (plo_en)  pat_q[31:0]   <= reg_wdata;
      if (phi_en)  pat_q[63:32]  <= reg_wdata;
    end
  end
endmodule

// File: rtl/memfill_fsm.sv
module memfill_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_pause,
  input  logic       cmd_restart,
  input  logic       size_ok,
  input  logic       beat_acc,
  input  logic       blk_last,
  input  logic       err_clr,
  output memfill_pkg::chan_st_e st_q,
  output logic       err_q,
  output logic       done_q,
  output logic       load
);
  import memfill_pkg::*;

  chan_st_e st_d;
  logic     err_set, err_d, fin;

  // Highest-priority command is judged against the current state.
  always_comb begin
    st_d    = st_q;
    err_set = 1'b0;
    load    = 1'b0;
    if (cmd_stop) begin
      if (st_q == ST_ACTIVE)      st_d = ST_IDLE;
      else if (st_q == ST_PAUSED) err_set = 1'b1;
    end else if (cmd_pause) begin
      if (st_q == ST_ACTIVE) st_d = ST_PAUSED;
      else                   err_set = 1'b1;
    end else if (cmd_restart) begin
      if (st_q == ST_PAUSED) st_d = ST_ACTIVE;
      else                   err_set = 1'b1;
    end else if (cmd_start) begin
      if ((st_q != ST_ACTIVE) && size_ok) begin
        st_d = ST_ACTIVE;
        load = 1'b1;
      end else begin
        err_set = 1'b1;
      end
    end
    fin = (st_q == ST_ACTIVE) && beat_acc && blk_last;
    if (fin) st_d = ST_IDLE;
    err_d = err_set || (err_q && !err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      done_q <= fin;
    end
  end
endmodule

// File: rtl/memfill_beat.sv
module memfill_beat #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] dst,
  input  logic [CNT_W-1:0]  beats,
  input  logic [63:0]       pat,
  input  logic [3:0]        dst_lim,
  output logic [ADDR_W-1:0] addr_q,
  output logic [63:0]       data_q,
  output logic              blk_last,
  output logic              burst_last
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);

  logic [CNT_W-1:0]  left_q, left_d;
  logic [ADDR_W-1:0] addr_d, bmask, nxt_addr;
  logic              en;

  assign en       = load || adv;
  assign nxt_addr = addr_q + STEP;
  assign bmask    = (STEP << dst_lim) - ADDR_W'(1);
  assign blk_last = (left_q == CNT_W'(1));
  assign burst_last = blk_last || ((nxt_addr & bmask) == '0);

  always_comb begin
    if (load) begin
      addr_d = {dst[ADDR_W-1:3], 3'b000};
      left_d = beats;
    end else begin
      addr_d = nxt_addr;
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
    end else begin
      if (en)   addr_q <= addr_d;
      if (en)   left_q <= left_d;
      if (load) data_q <= pat;
    end
  end
endmodule

// File: rtl/memfill_chan.sv
module memfill_chan #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_MIN = 8,
  parameter int SIZE_MAX = 1 << 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              mode_we,
  input  logic [2:0]        mode_val,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_pause,
  input  logic              cmd_restart,
  output logic [31:0]       ctrl_o,
  output logic [1:0]        state_o,
  output logic              err_o,
  output logic              done_o,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic              wr_last
);
  import memfill_pkg::*;

  localparam int CNT_W = $clog2((SIZE_MAX >> 3) + 1);

  logic [ADDR_W-1:0] dst_q;
  logic [31:0]       size_q;
  logic [63:0]       pat_q;
  logic              err_clr, size_ok, beat_acc, blk_last, load;
  chan_st_e          st_q;

  memfill_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_we(mode_we), .mode_val(mode_val),
    .ctrl_q(ctrl_o), .dst_q(dst_q), .size_q(size_q), .pat_q(pat_q),
    .err_clr(err_clr)
  );

  assign size_ok  = (size_q >= 32'(SIZE_MIN)) && (size_q <= 32'(SIZE_MAX));
  assign wr_valid = (st_q == ST_ACTIVE);
  assign beat_acc = wr_valid && wr_ready;
  assign state_o  = st_q;

  memfill_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_pause(cmd_pause), .cmd_restart(cmd_restart), .size_ok(size_ok),
    .beat_acc(beat_acc), .blk_last(blk_last), .err_clr(err_clr),
    .st_q(st_q), .err_q(err_o), .done_q(done_o), .load(load)
  );

  memfill_beat #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(beat_acc), .dst(dst_q),
    .beats(size_q[CNT_W+2:3]), .pat(pat_q), .dst_lim(ctrl_o[15:12]),
    .addr_q(wr_addr), .data_q(wr_data), .blk_last(blk_last),
    .burst_last(wr_last)
  );
endmodule

// File: rtl/memfill_chan_chk.sv
module memfill_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mode_we,
  input logic [31:0]       ctrl_o,
  input logic [1:0]        state_o,
  input logic              err_o,
  input logic              done_o,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data
);
  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

  p_offer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr) && $stable(wr_data));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> (wr_addr == $past(wr_addr) + ADDR_W'(8)) || done_o);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> state_o == 2'b00);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_mode_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 3'd0) && !mode_we |=> ctrl_o[2:0] == $past(ctrl_o[2:0]));

  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !(reg_we && (reg_addr == 3'd5) && reg_wdata[0]) |=> err_o);
endmodule

bind memfill_chan memfill_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_we(mode_we), .ctrl_o(ctrl_o),
  .state_o(state_o), .err_o(err_o), .done_o(done_o), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/memfill_chan_tb.sv
module memfill_chan_tb;
  localparam int AW = 32;
  localparam int SMIN = 16;
  localparam int SMAX = 512;

  logic clk, rst_n, reg_we, mode_we, wr_ready, wr_valid, wr_last, err_o, done_o;
  logic cmd_start, cmd_stop, cmd_pause, cmd_restart;
  logic [2:0] reg_addr, mode_val;
  logic [31:0] reg_wdata, ctrl_o;
  logic [1:0] state_o;
  logic [AW-1:0] wr_addr;
  logic [63:0] wr_data;
  int n_chk, n_fail;
  logic [7:0] lf;

  memfill_chan #(.ADDR_W(AW), .SIZE_MIN(SMIN), .SIZE_MAX(SMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_we(mode_we), .mode_val(mode_val),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_pause(cmd_pause),
    .cmd_restart(cmd_restart), .ctrl_o(ctrl_o), .state_o(state_o),
    .err_o(err_o), .done_o(done_o), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // c: 0 start, 1 stop, 2 pause, 3 restart (bench-local selector)
  task automatic cmd(input int c);
    cmd_start = (c == 0); cmd_stop = (c == 1); cmd_pause = (c == 2); cmd_restart = (c == 3);
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_pause = 0; cmd_restart = 0;
  endtask

  task automatic go_idle();
    if (state_o == 2'b10) cmd(3);
    if (state_o == 2'b01) cmd(1);
    wreg(3'd5, 32'h1);
  endtask

  task automatic setup(input logic [31:0] ptr, input logic [31:0] size, input int lim,
                       input logic [63:0] pat);
    wreg(3'd0, (32'(lim) << 12) | 32'h0000_0400);
    wreg(3'd1, ptr);
    wreg(3'd2, size);
    wreg(3'd3, pat[31:0]);
    wreg(3'd4, pat[63:32]);
  endtask

  task automatic run_fill(input logic [31:0] ptr, input logic [31:0] size, input int lim,
                          input int pause_at);
    logic [63:0] pat;
    logic [31:0] ea;
    int n, k;
    bit paused, rdy, el;
    pat = {ptr ^ 32'hA5A5_0000, size ^ 32'h5A5A_0000};
    setup(ptr, size, lim, pat);
    cmd(0);
    chk(state_o == 2'b01, "R3 start to active", 64'(state_o), 64'h1);
    ea = ptr & ~32'h7;
    n = int'(size >> 3);
    k = 0;
    paused = 0;
    while (k < n) begin
      if (k == pause_at && !paused) begin
        paused = 1;
        wr_ready = 0;
        cmd(2);
        chk(state_o == 2'b10 && !wr_valid, "R4 pause", {state_o, wr_valid}, 3'b100);
        wreg(3'd3, 32'h1234_5678);
        wreg(3'd4, 32'h9ABC_DEF0);
        chk(wr_addr == ea, "R4 position held", wr_addr, ea);
        cmd(3);
        chk(state_o == 2'b01 && wr_addr == ea, "R5 resume at held address", wr_addr, ea);
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rdy = lf[0] | lf[2];
      wr_ready = rdy;
      #1;
      chk(wr_valid, "R11 valid while beats remain", 64'(wr_valid), 64'h1);
      if (rdy) begin
        el = (k == n - 1) || (((ea + 32'd8) % (32'd8 << lim)) == 0);
        chk(wr_addr == ea, "R9 beat address", wr_addr, ea);
        chk(wr_data == pat, "R9 beat data", wr_data, pat);
        chk(wr_last == el, "R10 burst last", 64'(wr_last), 64'(el));
        ea = ea + 32'd8;
        k++;
      end
      @(negedge clk);
      wr_ready = 0;
    end
    chk(done_o && state_o == 2'b00, "R12 done and idle", {done_o, state_o}, 3'b100);
    @(negedge clk);
    chk(!done_o, "R12 done one cycle", 64'(done_o), 64'h0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; lf = 8'h5B;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; mode_we = 0; mode_val = 0;
    cmd_start = 0; cmd_stop = 0; cmd_pause = 0; cmd_restart = 0; wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(state_o == 2'b00 && !err_o && !done_o && !wr_valid, "R1 reset outputs",
        {state_o, err_o, done_o, wr_valid}, 0);
    chk(ctrl_o == 32'h0000_4400, "R1 reset control", ctrl_o, 32'h0000_4400);

    // R8 mode guard
    mode_we = 1; mode_val = 3'b100;
    @(negedge clk);
    mode_we = 0;
    chk(ctrl_o[2:0] == 3'b100, "R8 mode select loads", ctrl_o, 32'h4404);
    wreg(3'd0, 32'hFFFF_FFFF);
    chk(ctrl_o == 32'h0000_FF14, "R8 control write keeps mode", ctrl_o, 32'h0000_FF14);

    // R9 R10 R11 R12 sweep
    for (int li = 0; li < 4; li++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int si = 0; si < 4; si++) begin
          logic [31:0] p, s;
          int lim;
          lim = (li == 3) ? 4 : li;
          p = (pi == 0) ? 32'h100 : (pi == 1) ? 32'h138 : 32'h1FB;
          s = (si == 0) ? 32'd16 : (si == 1) ? 32'd29 : (si == 2) ? 32'd200 : 32'd512;
          run_fill(p, s, lim, (si % 2 == 1) ? int'(s >> 4) : -1);
        end
      end
    end

    // R13 and R3 range checks
    setup(32'h0, 32'(SMIN - 8), 4, 64'h0);
    cmd(0);
    chk(state_o == 2'b00 && err_o, "R3 size below min rejected", {state_o, err_o}, 3'b001);
    wreg(3'd5, 32'h0);
    chk(err_o, "R13 write zero keeps error", 64'(err_o), 64'h1);
    wreg(3'd5, 32'h1);
    chk(!err_o, "R13 write one clears", 64'(err_o), 64'h0);
    wreg(3'd2, 32'(SMAX + 8));
    cmd(0);
    chk(state_o == 2'b00 && err_o, "R3 size above max rejected", {state_o, err_o}, 3'b001);
    wreg(3'd5, 32'h1);

    // R2 R3 R4 R5 R6 command matrix, ready held low
    wreg(3'd2, 32'(SMAX));
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] es;
        bit ee;
        go_idle();
        if (s >= 1) cmd(0);
        if (s == 2) cmd(2);
        es = (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10;
        ee = 0;
        case (c)
          0: if (s == 1) ee = 1; else es = 2'b01;
          1: if (s == 1) es = 2'b00; else if (s == 2) ee = 1;
          2: if (s == 1) es = 2'b10; else ee = 1;
          default: if (s == 2) es = 2'b01; else ee = 1;
        endcase
        cmd(c);
        chk(state_o == es, "R2 R3 R4 R5 R6 state after command", 64'(state_o), 64'(es));
        chk(err_o == ee, "R3 R4 R5 R6 error after command", 64'(err_o), 64'(ee));
      end
    end

    // R6 abort mid block, R7 priority
    go_idle();
    wreg(3'd1, 32'h400);
    cmd(0);
    wr_ready = 1;
    repeat (3) @(negedge clk);
    wr_ready = 0;
    cmd_stop = 1; cmd_pause = 1;
    @(negedge clk);
    cmd_stop = 0; cmd_pause = 0;
    chk(state_o == 2'b00 && !err_o && !wr_valid, "R7 stop beats pause", {state_o, err_o}, 0);
    chk(!done_o, "R6 abort gives no done", 64'(done_o), 64'h0);
    cmd(0);
    chk(wr_addr == 32'h400, "R3 start reloads pointer", wr_addr, 32'h400);
    wr_ready = 1;
    repeat (2) @(negedge clk);
    wr_ready = 0;
    cmd(2);
    cmd_restart = 1; cmd_start = 1;
    @(negedge clk);
    cmd_restart = 0; cmd_start = 0;
    chk(state_o == 2'b01 && wr_addr == 32'h410, "R7 restart beats start", wr_addr, 32'h410);
    chk(!err_o, "R7 lower command ignored", 64'(err_o), 64'h0);
    go_idle();

    report();
    $finish;
  end
endmodule